// File: doc/BRIEF.md
# Raster Video Timing Generator

This block generates the raster timing for one display output: horizontal and vertical sync, horizontal and vertical blanking, and an active-video strobe. The lengths of every region come from timing registers that software loads through a plain register write port. Each line, and each field in the vertical direction, runs through four regions in a fixed order: back porch, active, front porch, then sync. The generator then wraps back to the back porch. Every region length is a separate programmable count.

Interlaced scan alternates two fields, and the even field comes first. The even field takes its vertical counts from a second register set, which software normally programs with a back porch one line shorter. In the odd field, vertical sync is shifted by half a line. A pixel-repetition control makes every horizontal region last two clocks per programmed count. At the first clock of every field, a one-clock frame-start pulse tells the upstream pixel source to begin filling. An interrupt is flagged when the raster enters the vertical front porch.

The generator starts when software sets the enable bit. In continuous mode, fields repeat until the enable bit is cleared. The field in progress then completes, and the readback of the enable bit drops to 0 once the generator has stopped. In one-shot mode, exactly one field is produced and the enable bit clears itself.

Top module: `raster_timing_gen`

## Requirements
- R1: During and after a synchronous reset, every timing output is 0, the interrupt is 0 and all registers read back as 0.
- R2: Each line is a back porch of HB clocks, then active of HA, front porch of HF, and sync of HS, with HB, HA, HF, HS taken from register 1 (bits 15:0 = back porch, 31:16 = active) and register 2 (15:0 = front porch, 31:16 = sync). `hsync_o` is high in the sync region and `hblank_o` is high outside the active region.
- R3: In progressive scan, each field is a back porch, then active, front porch and sync region measured in lines, with counts from register 3 (15:0 back porch, 31:16 active) and register 4 (15:0 front porch, 31:16 sync). `vsync_o` is high on sync lines and `vblank_o` is high on every non-active line.
- R4: `de_o` is high exactly when both the horizontal and the vertical position are in their active regions.
- R5: With control bit 3 (pixel repeat, value = factor minus one) set to 1, every horizontal region lasts twice its programmed count in clocks.
- R6: With control bit 2 (interlace) set, fields alternate starting with the even field (`field_o` = 0). The even field uses registers 5 and 6 (same layout as 3 and 4) for its vertical counts, and the odd field (`field_o` = 1) uses registers 3 and 4.
- R7: In an odd interlaced field, `vsync_o` changes only at the mid-line point, the clock whose line offset from the back-porch start equals half the total line length in clocks. At that point it takes the sync-line state of the current line.
- R8: `frame_start_o` is a one-clock pulse at the first clock of every field.
- R9: The interrupt status (register 7 bit 0) sets when the raster enters the first vertical front-porch line. `irq_o` is that status ANDed with control bit 4, and writing 1 to register 7 bit 0 clears it.
- R10: Control bit 1 (continuous) makes fields repeat. With it 0, exactly one field is produced, and then control bit 0 reads back 0.
- R11: After control bit 0 (enable) is cleared during a field, the field completes with bit 0 still reading 1. Bit 0 then reads 0, and all timing outputs stay 0 while stopped.
- R12: The register readback (`rd_data`, one clock after `rd_addr`) returns the written timing fields, control bits 4:1 as written, bit 0 as enable OR running, and register 7 as the interrupt status. All region counts must be at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Registered readback data |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| hblank_o | output | 1 | Horizontal blanking |
| vblank_o | output | 1 | Vertical blanking |
| de_o | output | 1 | Active-video strobe |
| field_o | output | 1 | Current field, 1 = odd |
| frame_start_o | output | 1 | One-clock pulse at each field start |
| irq_o | output | 1 | Front-porch interrupt |

## Verification
A region counter that slips by one clock moves every following `hsync_o` and `de_o` edge within the same line, so the per-clock reference comparison catches it in the first line it happens. A vertical counter or field flag in the wrong state shows up at the next line boundary as a misplaced `vblank_o` edge, a missing `frame_start_o` pulse or a `field_o` value that does not alternate. A stale mid-line sample shows up as a `vsync_o` edge half a line off. An interrupt or run-state bit stuck in the wrong value is visible on `irq_o`, or on the next readback of the control register, one clock later.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  localparam int REG_AW = 3;

  // register addresses
  localparam logic [REG_AW-1:0] A_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] A_HA   = 3'd1;
  localparam logic [REG_AW-1:0] A_HB   = 3'd2;
  localparam logic [REG_AW-1:0] A_VOA  = 3'd3;
  localparam logic [REG_AW-1:0] A_VOB  = 3'd4;
  localparam logic [REG_AW-1:0] A_VEA  = 3'd5;
  localparam logic [REG_AW-1:0] A_VEB  = 3'd6;
  localparam logic [REG_AW-1:0] A_IRQ  = 3'd7;

  // control bit positions
  localparam int B_EN    = 0;
  localparam int B_CONT  = 1;
  localparam int B_ILACE = 2;
  localparam int B_REP   = 3;
  localparam int B_IEN   = 4;

  // region codes, in scan order; also the index into a field bank
  typedef enum logic [1:0] {
    SEG_BACK  = 2'd0,
    SEG_VIS   = 2'd1,
    SEG_FRONT = 2'd2,
    SEG_SYNC  = 2'd3
  } seg_e;

  function automatic seg_e next_seg(input seg_e s);
    return seg_e'(s + 2'd1);
  endfunction

endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
#(
  parameter int FW = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [REG_AW-1:0]         wr_addr,
  input  logic [2*FW-1:0]           wr_data,
  input  logic [REG_AW-1:0]         rd_addr,
  output logic [2*FW-1:0]           rd_data,
  input  logic                      running,
  input  logic                      stop_pulse,
  input  logic                      vfp_enter,
  output logic                      en,
  output logic                      cont,
  output logic                      ilace,
  output logic                      rep,
  output logic                      ien,
  output logic                      irq_stat,
  output logic [3:0][FW-1:0]        h_fields,
  output logic [3:0][FW-1:0]        vo_fields,
  output logic [3:0][FW-1:0]        ve_fields
);

  localparam int DW    = 2 * FW;
  localparam int NBANK = 3;

  // bank 0 horizontal, bank 1 vertical primary/odd, bank 2 vertical even
  logic [NBANK-1:0][3:0][FW-1:0] bank;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < NBANK; b++) begin
        for (int p = 0; p < 2; p++) begin
          if (wr_addr == REG_AW'(1 + 2 * b + p)) begin
            bank[b][2*p]   <= wr_data[FW-1:0];
            bank[b][2*p+1] <= wr_data[DW-1:FW];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en    <= 1'b0;
      cont  <= 1'b0;
      ilace <= 1'b0;
      rep   <= 1'b0;
      ien   <= 1'b0;
    end else begin
      if (stop_pulse && !cont) en <= 1'b0;
      if (wr_en && wr_addr == A_CTRL) begin
        en    <= wr_data[B_EN];
        cont  <= wr_data[B_CONT];
        ilace <= wr_data[B_ILACE];
        rep   <= wr_data[B_REP];
        ien   <= wr_data[B_IEN];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_stat <= 1'b0;
    end else if (vfp_enter) begin
      irq_stat <= 1'b1;
    end else if (wr_en && wr_addr == A_IRQ && wr_data[0]) begin
      irq_stat <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        A_CTRL:  rd_data <= {{(DW-5){1'b0}}, ien, rep, ilace, cont, en | running};
        A_HA:    rd_data <= {bank[0][1], bank[0][0]};
        A_HB:    rd_data <= {bank[0][3], bank[0][2]};
        A_VOA:   rd_data <= {bank[1][1], bank[1][0]};
        A_VOB:   rd_data <= {bank[1][3], bank[1][2]};
        A_VEA:   rd_data <= {bank[2][1], bank[2][0]};
        A_VEB:   rd_data <= {bank[2][3], bank[2][2]};
        default: rd_data <= {{(DW-1){1'b0}}, irq_stat};
      endcase
    end
  end

  assign h_fields  = bank[0];
  assign vo_fields = bank[1];
  assign ve_fields = bank[2];

  AST_IRQ_W1C: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_IRQ && wr_data[0] && !vfp_enter) |=> !irq_stat); // R9

  AST_ONESHOT_DROP: assert property (@(posedge clk) disable iff (rst)
    (stop_pulse && !cont && !wr_en) |=> !en); // R10

endmodule

// File: rtl/vtg_hseq.sv
module vtg_hseq
  import vtg_pkg::*;
#(
  parameter int FW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clear,
  input  logic                 adv,
  input  logic [3:0][FW:0]     seg_len,
  output seg_e                 seg,
  output logic [FW+2:0]        pos,
  output logic                 line_end,
  output logic                 mid_hit
);

  localparam int PW = FW + 3;

  logic [FW:0]   cnt;
  logic [PW-1:0] htot;
  logic [PW-1:0] half;
  logic          seg_last;

  always_comb begin
    htot = '0;
    for (int i = 0; i < 4; i++) htot = htot + PW'(seg_len[i]);
    half     = htot >> 1;
    seg_last = (cnt == seg_len[seg] - 1'b1);
    line_end = adv && seg_last && (seg == SEG_SYNC);
    mid_hit  = adv && (pos == half);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      seg <= SEG_BACK;
      cnt <= '0;
      pos <= '0;
    end else if (adv) begin
      if (seg_last) begin
        cnt <= '0;
        seg <= next_seg(seg);
      end else begin
        cnt <= cnt + 1'b1;
      end
      pos <= line_end ? '0 : pos + 1'b1;
    end
  end

  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (rst)
    line_end |=> (pos == '0 && seg == SEG_BACK)); // R2

endmodule

// File: rtl/vtg_vseq.sv
module vtg_vseq
  import vtg_pkg::*;
#(
  parameter int FW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clear,
  input  logic                 step,
  input  logic [3:0][FW-1:0]   seg_len,
  output seg_e                 seg,
  output logic                 first_line,
  output logic                 frame_end,
  output logic                 fp_enter
);

  logic [FW-1:0] cnt;
  logic          seg_last;

  always_comb begin
    seg_last   = (cnt == seg_len[seg] - 1'b1);
    frame_end  = step && seg_last && (seg == SEG_SYNC);
    fp_enter   = step && seg_last && (seg == SEG_VIS);
    first_line = (seg == SEG_BACK) && (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      seg <= SEG_BACK;
      cnt <= '0;
    end else if (step) begin
      if (seg_last) begin
        cnt <= '0;
        seg <= next_seg(seg);
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_FP_ENTRY: assert property (@(posedge clk) disable iff (rst)
    fp_enter |=> (seg == SEG_FRONT)); // R9

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> first_line); // R8

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import vtg_pkg::*;
#(
  parameter int FW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [2:0]           wr_addr,
  input  logic [2*FW-1:0]      wr_data,
  input  logic [2:0]           rd_addr,
  output logic [2*FW-1:0]      rd_data,
  output logic                 hsync_o,
  output logic                 vsync_o,
  output logic                 hblank_o,
  output logic                 vblank_o,
  output logic                 de_o,
  output logic                 field_o,
  output logic                 frame_start_o,
  output logic                 irq_o
);

  logic                 en, cont, ilace, rep, ien, irq_stat;
  logic [3:0][FW-1:0]   h_fields, vo_fields, ve_fields;
  logic [3:0][FW:0]     h_len;
  logic [3:0][FW-1:0]   v_len;
  logic                 running;
  logic                 odd_field;
  logic                 vs_del;
  logic                 vs_next;
  logic                 start;
  logic                 keep_going;
  logic                 stop_pulse;
  seg_e                 hseg, vseg;
  logic [FW+2:0]        hpos;
  logic                 line_end, mid_hit;
  logic                 first_line, frame_end, fp_enter;
  logic                 vraw;
  logic                 use_even;

  vtg_regs #(.FW(FW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .running    (running),
    .stop_pulse (stop_pulse),
    .vfp_enter  (fp_enter),
    .en         (en),
    .cont       (cont),
    .ilace      (ilace),
    .rep        (rep),
    .ien        (ien),
    .irq_stat   (irq_stat),
    .h_fields   (h_fields),
    .vo_fields  (vo_fields),
    .ve_fields  (ve_fields)
  );

  // horizontal region lengths in clocks: doubled under pixel repeat
  for (genvar g = 0; g < 4; g++) begin : g_hlen
    assign h_len[g] = rep ? {h_fields[g], 1'b0} : {1'b0, h_fields[g]};
  end

  assign use_even   = ilace && !odd_field;
  assign v_len      = use_even ? ve_fields : vo_fields;
  assign start      = !running && en;
  assign keep_going = en && cont;
  assign stop_pulse = running && frame_end && !keep_going;

  vtg_hseq #(.FW(FW)) u_hseq (
    .clk      (clk),
    .rst      (rst),
    .clear    (start),
    .adv      (running),
    .seg_len  (h_len),
    .seg      (hseg),
    .pos      (hpos),
    .line_end (line_end),
    .mid_hit  (mid_hit)
  );

  vtg_vseq #(.FW(FW)) u_vseq (
    .clk        (clk),
    .rst        (rst),
    .clear      (start),
    .step       (line_end),
    .seg_len    (v_len),
    .seg        (vseg),
    .first_line (first_line),
    .frame_end  (frame_end),
    .fp_enter   (fp_enter)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      running   <= 1'b0;
      odd_field <= 1'b0;
    end else if (start) begin
      running   <= 1'b1;
      odd_field <= 1'b0;
    end else if (frame_end) begin
      if (keep_going) begin
        if (ilace) odd_field <= ~odd_field;
      end else begin
        running <= 1'b0;
      end
    end
  end

  // odd-field vertical sync: resampled only at the mid-line point
  assign vraw    = (vseg == SEG_SYNC);
  assign vs_next = mid_hit ? vraw : vs_del;

  always_ff @(posedge clk) begin
    if (rst || start) vs_del <= 1'b0;
    else              vs_del <= vs_next;
  end

  always_ff @(posedge clk) begin
    if (rst || !running) begin
      hsync_o       <= 1'b0;
      vsync_o       <= 1'b0;
      hblank_o      <= 1'b0;
      vblank_o      <= 1'b0;
      de_o          <= 1'b0;
      field_o       <= 1'b0;
      frame_start_o <= 1'b0;
    end else begin
      hsync_o       <= (hseg == SEG_SYNC);
      vsync_o       <= (ilace && odd_field) ? vs_next : vraw;
      hblank_o      <= (hseg != SEG_VIS);
      vblank_o      <= (vseg != SEG_VIS);
      de_o          <= (hseg == SEG_VIS) && (vseg == SEG_VIS);
      field_o       <= odd_field;
      frame_start_o <= (hpos == '0) && first_line;
    end
  end

  assign irq_o = irq_stat && ien;

  AST_DE_UNBLANKED: assert property (@(posedge clk) disable iff (rst)
    de_o |-> (!hblank_o && !vblank_o)); // R4

  AST_HSYNC_BLANKED: assert property (@(posedge clk) disable iff (rst)
    hsync_o |-> (hblank_o && !de_o)); // R2

  AST_FSTART_PULSE: assert property (@(posedge clk) disable iff (rst)
    frame_start_o |=> !frame_start_o); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !running |=> (!de_o && !hsync_o && !vsync_o && !frame_start_o)); // R11

  AST_EVEN_FIRST: assert property (@(posedge clk) disable iff (rst)
    start |=> !odd_field); // R6

endmodule

// File: tb/raster_timing_gen_test.sv
module raster_timing_gen_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        hsync_o, vsync_o, hblank_o, vblank_o, de_o, field_o, frame_start_o, irq_o;

  always #5 clk = ~clk;

  raster_timing_gen uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .hblank_o(hblank_o), .vblank_o(vblank_o), .de_o(de_o), .field_o(field_o),
    .frame_start_o(frame_start_o), .irq_o(irq_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit cmp_on   = 1'b0;

  task automatic check(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, nm, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  m_f [3][4];
  bit  m_en, m_cont, m_il, m_rep, m_ien, m_stat;
  bit  m_run, m_odd, m_hold;
  int  m_hp, m_ln;
  logic e_hs, e_vs, e_hb, e_vb, e_de, e_fd, e_fs, e_irq;
  logic [31:0] e_rd;

  function automatic int region(input int p, input int a, input int b, input int c);
    if (p < a) return 0;
    if (p < a + b) return 1;
    if (p < a + b + c) return 2;
    return 3;
  endfunction

  always @(posedge clk) begin
    int hl[4];
    int vl[4];
    int htot, vtot, hr, vr, vb;
    bit stop, setirq;
    if (rst) begin
      foreach (m_f[i, j]) m_f[i][j] = 0;
      {m_en, m_cont, m_il, m_rep, m_ien, m_stat, m_run, m_odd, m_hold} = '0;
      m_hp = 0; m_ln = 0;
      {e_hs, e_vs, e_hb, e_vb, e_de, e_fd, e_fs, e_irq} = '0;
      e_rd = '0;
    end else begin
      vb = (m_il && !m_odd) ? 2 : 1;
      htot = 0;
      for (int i = 0; i < 4; i++) begin
        hl[i] = m_f[0][i] * (m_rep ? 2 : 1);
        vl[i] = m_f[vb][i];
        htot += hl[i];
      end
      vtot = vl[0] + vl[1] + vl[2] + vl[3];
      if (m_run) begin
        hr = region(m_hp, hl[0], hl[1], hl[2]);
        vr = region(m_ln, vl[0], vl[1], vl[2]);
        if (m_hp == htot / 2) m_hold = (vr == 3);
        e_hs = (hr == 3);
        e_hb = (hr != 1);
        e_vb = (vr != 1);
        e_de = (hr == 1) && (vr == 1);
        e_vs = (m_il && m_odd) ? m_hold : (vr == 3);
        e_fd = m_odd;
        e_fs = (m_hp == 0) && (m_ln == 0);
      end else begin
        {e_hs, e_vs, e_hb, e_vb, e_de, e_fd, e_fs} = '0;
      end
      case (rd_addr)
        3'd0: e_rd = {27'd0, m_ien, m_rep, m_il, m_cont, m_en | m_run};
        3'd7: e_rd = {31'd0, m_stat};
        default: e_rd = {m_f[(rd_addr-1)/2][2*((rd_addr-1)%2)+1][15:0],
                         m_f[(rd_addr-1)/2][2*((rd_addr-1)%2)][15:0]};
      endcase
      stop = 1'b0; setirq = 1'b0;
      if (!m_run) begin
        if (m_en) begin m_run = 1; m_hp = 0; m_ln = 0; m_odd = 0; m_hold = 0; end
      end else begin
        m_hp++;
        if (m_hp == htot) begin
          m_hp = 0;
          m_ln++;
          if (m_ln == vtot) begin
            m_ln = 0;
            if (m_en && m_cont) begin
              if (m_il) m_odd = !m_odd;
            end else begin
              m_run = 0; stop = 1;
            end
          end else if (m_ln == vl[0] + vl[1]) begin
            setirq = 1;
          end
        end
      end
      if (stop && !m_cont) m_en = 0;
      if (wr_en) begin
        if (wr_addr == 3'd0) begin
          m_en = wr_data[0]; m_cont = wr_data[1]; m_il = wr_data[2];
          m_rep = wr_data[3]; m_ien = wr_data[4];
        end else if (wr_addr != 3'd7) begin
          m_f[(wr_addr-1)/2][2*((wr_addr-1)%2)]   = int'(wr_data[15:0]);
          m_f[(wr_addr-1)/2][2*((wr_addr-1)%2)+1] = int'(wr_data[31:16]);
        end else if (wr_data[0]) begin
          m_stat = 0;
        end
      end
      if (setirq) m_stat = 1;
      e_irq = m_stat && m_ien;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      check(m_rep ? "R5" : "R2", "hsync", 32'(hsync_o), 32'(e_hs));
      check("R2", "hblank", 32'(hblank_o), 32'(e_hb));
      check(m_il ? "R6" : "R3", "vblank", 32'(vblank_o), 32'(e_vb));
      check((m_il && field_o) ? "R7" : "R3", "vsync", 32'(vsync_o), 32'(e_vs));
      check("R4", "de", 32'(de_o), 32'(e_de));
      check("R6", "field", 32'(field_o), 32'(e_fd));
      check("R8", "frame_start", 32'(frame_start_o), 32'(e_fs));
      check("R9", "irq", 32'(irq_o), 32'(e_irq));
      check("R12", "rd_data", rd_data, e_rd);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_fs();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (frame_start_o) break;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int fs_count;
    idle(3);
    // R1: reset state
    check("R1", "outputs", {24'd0, hsync_o, vsync_o, hblank_o, vblank_o, de_o, field_o, frame_start_o, irq_o}, 32'd0);
    check("R1", "rd_data", rd_data, 32'd0);
    rst = 1'b0;
    cmp_on = 1'b1;

    wr(3'd1, {16'd8, 16'd3});
    wr(3'd2, {16'd3, 16'd2});
    wr(3'd3, {16'd4, 16'd2});
    wr(3'd4, {16'd2, 16'd1});
    wr(3'd5, {16'd4, 16'd1});
    wr(3'd6, {16'd2, 16'd1});
    rd_addr = 3'd1;
    idle(2);
    check("R12", "timing readback", rd_data, {16'd8, 16'd3});
    rd_addr = 3'd6;
    idle(2);
    check("R12", "even readback", rd_data, {16'd2, 16'd1});

    // progressive continuous with interrupt
    rd_addr = 3'd7;
    wr(3'd0, 32'b10011);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (irq_o) break;
    end
    check("R9", "irq raised", 32'(irq_o), 32'd1);
    wr(3'd7, 32'd1);
    check("R9", "irq cleared", 32'(irq_o), 32'd0);
    idle(300);

    // stop by clearing enable mid-field
    rd_addr = 3'd0;
    wait_fs();
    wr(3'd0, 32'b10010);
    idle(1);
    check("R11", "enable readback while finishing", 32'(rd_data[0]), 32'd1);
    idle(300);
    check("R11", "enable readback after stop", 32'(rd_data[0]), 32'd0);
    check("R11", "quiet outputs", {29'd0, de_o, hsync_o, vsync_o}, 32'd0);

    // pixel repetition
    wr(3'd0, 32'b01011);
    idle(650);
    wr(3'd0, 32'b01010);
    idle(400);

    // interlaced, single and double rate
    wr(3'd0, 32'b00111);
    idle(700);
    wr(3'd0, 32'b00110);
    idle(400);
    wr(3'd0, 32'b01111);
    idle(1300);
    wr(3'd0, 32'b01110);
    idle(700);

    // one-shot
    rd_addr = 3'd0;
    fs_count = 0;
    wr(3'd0, 32'b00001);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (frame_start_o) fs_count++;
    end
    check("R10", "one-shot field count", fs_count, 32'd1);
    check("R10", "one-shot enable readback", 32'(rd_data[0]), 32'd0);

    cmp_on = 1'b0;
    summary();
    $finish;
  end

endmodule